// File: doc/BRIEF.md
# Set-Features Command Handler

This block is the register unit behind an ATA-style Set Features command in a storage device. Each command arrives as a one-cycle strobe carrying a feature code and a sector-count argument byte. The block decodes the pair, updates the stored settings and answers one cycle later with a done pulse and an abort bit. The stored settings are the transfer mode, the adaptive power-saving mode, the write-cache enable and the revert-to-defaults flag. All current settings are driven on output ports, so that an identify-style readout can report them.

The transfer-mode argument is a packed byte: five type bits above three mode-number bits. The power-mode argument is a ranged value that maps to one of three modes. The deepest mode also carries a sub-level. A bad argument or an unknown feature code aborts the command and changes nothing. A sticky input reports that the spare-sector reassignment capacity is used up. While it is set, write cache is held off, but the enable command still completes without error. The asynchronous reset loads the power-on defaults. A soft-reset request reloads them only when revert-to-defaults has been enabled.

Top module: `sf_cmd_top`

## Requirements
- R1: After reset the outputs hold their power-on defaults:
  - write cache on, unless spare_exhausted is high
  - power mode enabled, mode 1, sub-level 0
  - ECC length 4
  - read look-ahead on
  - revert off
  - transfer code 00h
  - done low
- R2: Every cycle with cmd_valid high is followed in the next cycle by exactly one done pulse. done is low after any cycle without cmd_valid, and abort is high only while done is high.
- R3: Feature 03h stores the argument as xfer_code when it is legal. The argument's type is bits [7:3] and its mode number is bits [2:0]. The legal pairs are:
  - type 0 with mode 0 or 1
  - type 1 with mode 0 to 4
  - types 2, 4 and 8 with mode 0 to 2
- R4: Feature 03h with any other argument aborts and leaves every setting unchanged.
- R5: Feature 05h with an argument from 01h to FEh sets pm_enable and picks the mode. The mapping is:
  - C0h–FEh gives mode 0.
  - 80h–BFh gives mode 1.
  - 01h–7Fh gives mode 2. Its pm_sublevel is 0 for 60h–7Fh, 1 for 30h–5Fh and 2 for 01h–2Fh.
  - pm_sublevel is 0 in modes 0 and 1.
- R6: Feature 05h with argument 00h or FFh aborts and leaves every setting unchanged.
- R7: Feature 85h completes without abort and clears pm_enable, pm_mode and pm_sublevel.
- R8: Feature 02h always completes without abort. It turns write cache on only when spare_exhausted is low.
- R9: While spare_exhausted is high, wcache_en is low in the same cycle. The stored enable is also cleared, so the cache stays off after the flag drops until another 02h command.
- R10: Feature CCh completes without abort and sets revert_en, which then stays set until the asynchronous reset.
- R11: Any feature code other than 02h, 03h, 05h, 85h and CCh aborts and leaves every setting unchanged.
- R12: soft_reset_req with revert_en set reloads the defaults of R1, except that revert_en stays set. With revert_en clear it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_feature | input | 8 | Feature code |
| cmd_count | input | 8 | Sector-count argument byte |
| soft_reset_req | input | 1 | Soft-reset request |
| spare_exhausted | input | 1 | Sticky flag: reassignment capacity used up |
| done | output | 1 | Command-complete pulse, one cycle after the strobe |
| abort | output | 1 | Abort status, valid with done |
| xfer_code | output | 8 | Stored transfer-mode byte (type in [7:3], mode in [2:0]) |
| pm_enable | output | 1 | Adaptive power mode enabled |
| pm_mode | output | 2 | Adaptive power mode 0..2 |
| pm_sublevel | output | 2 | Sub-level of mode 2: 0 performance, 1 intermediate, 2 low power |
| wcache_en | output | 1 | Effective write-cache enable |
| lookahead_en | output | 1 | Read look-ahead enable |
| ecc_bytes | output | 8 | ECC length in bytes |
| revert_en | output | 1 | Revert-to-defaults on soft reset enabled |

## Verification
The assertions check on every cycle:
- the strobe-to-done pairing, and that abort is seen only with done
- that an aborted command left the settings as they were
- that the exhaustion flag holds the cache off
- that a disabled power mode reads as mode 0
- that the stored transfer code is always a legal one
- that revert stays set once enabled

Only the bench scenarios show that each argument value decodes to the right mode and sub-level. The bench sweeps all 256 argument bytes under both 03h and 05h. The scenarios also show that the cache stays off after the flag drops, and that a soft reset behaves differently with revert enabled and disabled.

// File: rtl/sf_pkg.sv
package sf_pkg;

  localparam logic [7:0] FC_WCACHE_ON = 8'h02;
  localparam logic [7:0] FC_XFER      = 8'h03;
  localparam logic [7:0] FC_PM_ON     = 8'h05;
  localparam logic [7:0] FC_PM_OFF    = 8'h85;
  localparam logic [7:0] FC_REVERT_ON = 8'hCC;

  // power-mode argument thresholds (lower bound of each band)
  localparam logic [7:0] PM_M0_LO  = 8'hC0;
  localparam logic [7:0] PM_M1_LO  = 8'h80;
  localparam logic [7:0] PM_PERF_LO = 8'h60;
  localparam logic [7:0] PM_MID_LO = 8'h30;

  typedef struct packed {
    logic [7:0] xfer_code;
    logic       pm_en;
    logic [1:0] pm_mode;
    logic [1:0] pm_sub;
    logic       wc_store;
    logic       revert;
  } sf_settings_t;

  function automatic sf_settings_t sf_defaults();
    sf_settings_t s;
    s.xfer_code = 8'h00;
    s.pm_en     = 1'b1;
    s.pm_mode   = 2'd1;
    s.pm_sub    = 2'd0;
    s.wc_store  = 1'b1;
    s.revert    = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/sf_xfer_decode.sv
module sf_xfer_decode #(
  parameter int unsigned PIO_FC_MAX = 4,
  parameter int unsigned DMA_MAX    = 2,
  parameter int unsigned N_DMA_TYPES = 3
) (
  input  logic [7:0] code,
  output logic       legal
);
  localparam int unsigned TYPE_W = 5;
  localparam int unsigned MODE_W = 3;

  logic [TYPE_W-1:0] ttype;
  logic [MODE_W-1:0] mnum;
  logic [N_DMA_TYPES-1:0] dma_hit;

  assign ttype = code[7:3];
  assign mnum  = code[2:0];

  // one-hot DMA type bits start above the flow-control type bit
  for (genvar g = 0; g < N_DMA_TYPES; g++) begin : g_dma
    assign dma_hit[g] = (ttype == TYPE_W'(1 << (g + 1))) &&
                        (32'(mnum) <= DMA_MAX);
  end

  always_comb begin
    legal = |dma_hit;
    if (ttype == '0 && mnum <= MODE_W'(1)) legal = 1'b1;
    if (ttype == TYPE_W'(1) && 32'(mnum) <= PIO_FC_MAX) legal = 1'b1;
  end
endmodule

// File: rtl/sf_power_decode.sv
module sf_power_decode
  import sf_pkg::*;
(
  input  logic [7:0] level,
  output logic       legal,
  output logic [1:0] mode,
  output logic [1:0] sub
);
  always_comb begin
    legal = (level != 8'h00) && (level != 8'hFF);
    mode  = 2'd2;
    sub   = 2'd0;
    if (level >= PM_M0_LO) begin
      mode = 2'd0;
    end else if (level >= PM_M1_LO) begin
      mode = 2'd1;
    end else if (level >= PM_PERF_LO) begin
      sub = 2'd0;
    end else if (level >= PM_MID_LO) begin
      sub = 2'd1;
    end else begin
      sub = 2'd2;
    end
  end
endmodule

// File: rtl/sf_settings_reg.sv
module sf_settings_reg
  import sf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         upd_en,
  input  sf_settings_t upd,
  input  logic         exhausted,
  output sf_settings_t q
);
  sf_settings_t d;

  always_comb begin
    d = q;
    if (soft_rst && q.revert) begin
      d        = sf_defaults();
      d.revert = 1'b1;
    end else if (upd_en) begin
      d = upd;
    end
    if (exhausted) d.wc_store = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= sf_defaults();
    else        q <= d;
  end
endmodule

// File: rtl/sf_cmd_top.sv
module sf_cmd_top
  import sf_pkg::*;
#(
  parameter int unsigned ECC_LEN    = 4,
  parameter int unsigned PIO_FC_MAX = 4,
  parameter int unsigned DMA_MAX    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_feature,
  input  logic [7:0] cmd_count,
  input  logic       soft_reset_req,
  input  logic       spare_exhausted,
  output logic       done,
  output logic       abort,
  output logic [7:0] xfer_code,
  output logic       pm_enable,
  output logic [1:0] pm_mode,
  output logic [1:0] pm_sublevel,
  output logic       wcache_en,
  output logic       lookahead_en,
  output logic [7:0] ecc_bytes,
  output logic       revert_en
);
  sf_settings_t cur, cand;
  logic xfer_ok, pm_ok, bad_d, upd_en;
  logic [1:0] pm_m, pm_s;

  sf_xfer_decode #(.PIO_FC_MAX(PIO_FC_MAX), .DMA_MAX(DMA_MAX), .N_DMA_TYPES(3))
    xdec_i (.code(cmd_count), .legal(xfer_ok));

  sf_power_decode pdec_i (.level(cmd_count), .legal(pm_ok), .mode(pm_m), .sub(pm_s));

  always_comb begin
    cand  = cur;
    bad_d = 1'b0;
    unique case (cmd_feature)
      FC_WCACHE_ON: cand.wc_store = 1'b1;
      FC_XFER: begin
        if (xfer_ok) cand.xfer_code = cmd_count;
        else         bad_d = 1'b1;
      end
      FC_PM_ON: begin
        if (pm_ok) begin
          cand.pm_en   = 1'b1;
          cand.pm_mode = pm_m;
          cand.pm_sub  = pm_s;
        end else begin
          bad_d = 1'b1;
        end
      end
      FC_PM_OFF: begin
        cand.pm_en   = 1'b0;
        cand.pm_mode = 2'd0;
        cand.pm_sub  = 2'd0;
      end
      FC_REVERT_ON: cand.revert = 1'b1;
      default:      bad_d = 1'b1;
    endcase
  end

  assign upd_en = cmd_valid && !bad_d;

  sf_settings_reg sreg_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_reset_req), .upd_en(upd_en),
    .upd(cand), .exhausted(spare_exhausted), .q(cur)
  );

  logic done_d, abort_d;
  always_comb begin
    done_d  = cmd_valid;
    abort_d = cmd_valid && bad_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      abort <= 1'b0;
    end else begin
      done  <= done_d;
      abort <= abort_d;
    end
  end

  assign xfer_code    = cur.xfer_code;
  assign pm_enable    = cur.pm_en;
  assign pm_mode      = cur.pm_mode;
  assign pm_sublevel  = cur.pm_sub;
  assign wcache_en    = cur.wc_store && !spare_exhausted;
  assign lookahead_en = 1'b1;
  assign ecc_bytes    = 8'(ECC_LEN);
  assign revert_en    = cur.revert;
endmodule

// File: rtl/sf_cmd_chk.sv
module sf_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       soft_reset_req,
  input logic       spare_exhausted,
  input logic       done,
  input logic       abort,
  input logic [7:0] xfer_code,
  input logic       pm_enable,
  input logic [1:0] pm_mode,
  input logic [1:0] pm_sublevel,
  input logic       wcache_en,
  input logic       revert_en
);
  logic       past_ok;
  logic [4:0] ty;
  logic [2:0] mn;
  assign ty = xfer_code[7:3];
  assign mn = xfer_code[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done); // R2
  AST_ABORT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> done); // R2
  AST_ABORT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && abort && !$past(soft_reset_req)) |->
      ($stable(xfer_code) && $stable(pm_enable) && $stable(pm_mode) &&
       $stable(pm_sublevel) && $stable(revert_en))); // R11
  AST_EXHAUST_CACHE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    spare_exhausted |-> !wcache_en); // R9
  AST_PM_OFF_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_enable |-> (pm_mode == 2'd0 && pm_sublevel == 2'd0)); // R7
  AST_XFER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ty == 5'd0 && mn <= 3'd1) || (ty == 5'd1 && mn <= 3'd4) ||
    ((ty == 5'd2 || ty == 5'd4 || ty == 5'd8) && mn <= 3'd2)); // R3
  AST_REVERT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(revert_en)) |-> revert_en); // R10
endmodule

bind sf_cmd_top sf_cmd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .soft_reset_req(soft_reset_req), .spare_exhausted(spare_exhausted),
  .done(done), .abort(abort), .xfer_code(xfer_code), .pm_enable(pm_enable),
  .pm_mode(pm_mode), .pm_sublevel(pm_sublevel), .wcache_en(wcache_en),
  .revert_en(revert_en)
);

// File: tb/sf_cmd_top_tb_top.sv
module sf_cmd_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_feature = 8'h00;
  logic [7:0] cmd_count = 8'h00;
  logic       soft_reset_req = 1'b0;
  logic       spare_exhausted = 1'b0;
  logic       done, abort, pm_enable, wcache_en, lookahead_en, revert_en;
  logic [7:0] xfer_code, ecc_bytes;
  logic [1:0] pm_mode, pm_sublevel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sf_cmd_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_feature(cmd_feature),
    .cmd_count(cmd_count), .soft_reset_req(soft_reset_req),
    .spare_exhausted(spare_exhausted), .done(done), .abort(abort),
    .xfer_code(xfer_code), .pm_enable(pm_enable), .pm_mode(pm_mode),
    .pm_sublevel(pm_sublevel), .wcache_en(wcache_en), .lookahead_en(lookahead_en),
    .ecc_bytes(ecc_bytes), .revert_en(revert_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // applies one command; returns at the negedge where done is visible
  task automatic send(input logic [7:0] f, input logic [7:0] c);
    @(negedge clk);
    cmd_feature = f; cmd_count = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 done", done, 1);
  endtask

  task automatic t_reset();
    chk("R1 xfer", xfer_code, 8'h00);
    chk("R1 pm_en", pm_enable, 1);
    chk("R1 pm_mode", pm_mode, 1);
    chk("R1 pm_sub", pm_sublevel, 0);
    chk("R1 wcache", wcache_en, 1);
    chk("R1 ecc", ecc_bytes, 4);
    chk("R1 lookahead", lookahead_en, 1);
    chk("R1 revert", revert_en, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_xfer_sweep();
    logic [7:0] prev;
    prev = xfer_code;
    for (int i = 0; i < 256; i++) begin
      logic [4:0] ty; logic [2:0] mn; bit ok;
      ty = 5'(i >> 3); mn = 3'(i);
      ok = (ty == 0 && mn <= 1) || (ty == 1 && mn <= 4) ||
           ((ty == 2 || ty == 4 || ty == 8) && mn <= 2);
      send(8'h03, 8'(i));
      if (ok) begin
        chk("R3 abort", abort, 0);
        chk("R3 xfer", xfer_code, i);
        prev = 8'(i);
      end else begin
        chk("R4 abort", abort, 1);
        chk("R4 xfer kept", xfer_code, prev);
        chk("R4 pm kept", pm_mode, 1);
      end
    end
    @(negedge clk);
    chk("R2 single done", done, 0);
  endtask

  task automatic t_power_sweep();
    int pm = 1, ps = 0, pe = 1;
    for (int i = 0; i < 256; i++) begin
      send(8'h05, 8'(i));
      if (i == 0 || i == 255) begin
        chk("R6 abort", abort, 1);
        chk("R6 mode kept", pm_mode, pm);
        chk("R6 sub kept", pm_sublevel, ps);
        chk("R6 en kept", pm_enable, pe);
      end else begin
        pe = 1; ps = 0;
        if (i >= 'hC0) pm = 0;
        else if (i >= 'h80) pm = 1;
        else begin
          pm = 2;
          ps = (i >= 'h60) ? 0 : (i >= 'h30) ? 1 : 2;
        end
        chk("R5 abort", abort, 0);
        chk("R5 en", pm_enable, 1);
        chk("R5 mode", pm_mode, pm);
        chk("R5 sub", pm_sublevel, ps);
      end
    end
  endtask

  task automatic t_pm_off();
    send(8'h05, 8'h20);
    send(8'h85, 8'h00);
    chk("R7 abort", abort, 0);
    chk("R7 en", pm_enable, 0);
    chk("R7 mode", pm_mode, 0);
    chk("R7 sub", pm_sublevel, 0);
  endtask

  task automatic t_cache();
    @(negedge clk);
    spare_exhausted = 1'b1;
    #1;
    chk("R9 forced off", wcache_en, 0);
    send(8'h02, 8'h00);
    chk("R8 no abort when exhausted", abort, 0);
    chk("R8 stays off", wcache_en, 0);
    @(negedge clk);
    spare_exhausted = 1'b0;
    #1;
    chk("R9 stored cleared", wcache_en, 0);
    send(8'h02, 8'h00);
    chk("R8 abort", abort, 0);
    chk("R8 on", wcache_en, 1);
  endtask

  task automatic t_unknown();
    logic [7:0] codes [6] = '{8'h00, 8'h01, 8'h04, 8'h66, 8'h82, 8'hFF};
    logic [7:0] xc; logic [1:0] pm;
    xc = xfer_code; pm = pm_mode;
    foreach (codes[k]) begin
      send(codes[k], 8'h41);
      chk("R11 abort", abort, 1);
      chk("R11 xfer kept", xfer_code, xc);
      chk("R11 pm kept", pm_mode, pm);
      chk("R11 revert kept", revert_en, 0);
      chk("R11 cache kept", wcache_en, 1);
    end
  endtask

  task automatic soft_pulse();
    @(negedge clk);
    soft_reset_req = 1'b1;
    @(negedge clk);
    soft_reset_req = 1'b0;
  endtask

  task automatic t_soft_reset();
    send(8'h03, 8'h42);
    send(8'h05, 8'hC5);
    soft_pulse();
    chk("R12 no revert xfer", xfer_code, 8'h42);
    chk("R12 no revert mode", pm_mode, 0);
    send(8'hCC, 8'h00);
    chk("R10 abort", abort, 0);
    chk("R10 revert", revert_en, 1);
    soft_pulse();
    chk("R12 xfer default", xfer_code, 8'h00);
    chk("R12 mode default", pm_mode, 1);
    chk("R12 en default", pm_enable, 1);
    chk("R12 revert kept", revert_en, 1);
    chk("R10 revert held", revert_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer_sweep();
    t_power_sweep();
    t_pm_off();
    t_cache();
    t_unknown();
    t_soft_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule